// File: doc/BRIEF.md
# Configuration Request Packet Builder

This block turns a single configuration-space access into a short burst of 64-bit beats for a transaction-layer transmit path. Each request names the target bus, the device/function number, the byte offset, the access size (1, 2 or 4 bytes), the direction, and for writes the data. The block works out the byte enables and moves the write data onto the correct byte lanes. It chooses between the type 0 and type 1 request encodings, builds the three header dwords, and sends them out with start-of-packet and end-of-packet flags under a valid/ready handshake. Only the request side is built here. Receiving completions and the link layer are handled elsewhere.

The block holds the number of the root bus, which is the bus the port itself sits on. It filters accesses to that bus before anything is sent. Only device 0 can be reached there, and the first base address register of the root device is hidden. A write that lands on the root device's primary-bus-number register reloads the held root bus number.

The controller is a four-state machine. `ST_IDLE` accepts a request. A request that is filtered out stays in `ST_IDLE` and raises a reject pulse. A request that is not filtered moves to `ST_HEAD`. When its beat is taken, `ST_HEAD` moves to `ST_PAD` for a write to a quadword-aligned offset, and to `ST_TAIL` in every other case. `ST_PAD` moves to `ST_TAIL` when its beat is taken. `ST_TAIL` returns to `ST_IDLE` when its beat is taken.

Top module: `cfg_req_builder`

## Requirements
- R1: The format/type byte is 0x04 for a type 0 read, 0x44 for a type 0 write, 0x05 for a type 1 read and 0x45 for a type 1 write. Type 0 is used when the target bus equals the held root bus number. Type 1 is used for every other bus.
- R2: Header dword 0 carries the format/type byte in bits 31:24 and the value 1 in bits 23:0.
- R3: Header dword 1 carries the requester ID in bits 31:16. The requester ID is the root bus number in its upper byte and zero in its lower byte. Dword 1 carries the tag in bits 15:8, which is 0x1D for a read and 0x10 for a write. The byte enables sit in bits 3:0 and bits 7:4 are zero.
- R4: Header dword 2 carries the bus in bits 31:24 and the device/function in bits 23:16. Bits 15:0 hold the offset with its two low bits forced to zero.
- R5: The size code `req_size` is 0 for 1 byte, 1 for 2 bytes, and 2 or 3 for 4 bytes. The byte enables are 1<<(off&3), 3<<(off&3) and 0xF respectively, kept to four bits. Write data is shifted left by 8*(off&3) within 32 bits.
- R6: In each beat, bits 31:0 hold the earlier dword and bits 63:32 the later one. Beat 1 holds dwords 0 and 1 with SOP set. A write whose offset has bit 2 clear produces a second beat {0, dword 2} with no flags and a third beat {0, shifted data} with EOP set. Every other request produces a second beat {data or zero for reads, dword 2} with EOP set. SOP and EOP are never set on the same beat.
- R7: An access to the root bus whose device number (devfn bits 7:3) is not zero sends no beats. It pulses `reject_valid` for one cycle, one clock after acceptance, with `reject_code` = 1.
- R8: An access to the root bus with devfn 0 and offset exactly 0x10 sends no beats and rejects with `reject_code` = 2. The same offset on any other bus is sent normally.
- R9: The root bus number resets to `ROOT_INIT`, which defaults to 0. When the last beat of a write is accepted, the low 8 bits of the shifted write data become the new root bus number, provided all of the following hold: the write targets the root bus, devfn is 0, the offset with its low two bits cleared is 0x18, and byte enable bit 0 is set. The root bus number changes at no other time.
- R10: While a packet is in flight, `busy` is high and `req_ready` is low, and requests are ignored. A beat that is not accepted keeps its data and flags unchanged.
- R11: After reset, `busy`, `beat_valid` and `reject_valid` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_write | input | 1 | 1 for write, 0 for read |
| req_bus | input | BUS_W | Target bus number |
| req_devfn | input | DEVFN_W | Target device/function |
| req_off | input | OFF_W | Byte offset in configuration space |
| req_size | input | 2 | Size code: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| req_wdata | input | 32 | Write data, right-aligned |
| busy | output | 1 | Packet in flight |
| reject_valid | output | 1 | One-cycle pulse for a filtered request |
| reject_code | output | 2 | 1 = no such device, 2 = hidden register |
| root_bus | output | BUS_W | Current root bus number |
| beat_valid | output | 1 | Beat present |
| beat_ready | input | 1 | Beat taken by the sink |
| beat_data | output | 64 | Beat payload |
| beat_sop | output | 1 | First beat of a packet |
| beat_eop | output | 1 | Last beat of a packet |

## Verification
The bound checker enforces the handshake on every cycle:
- beats are held steady under back-pressure;
- no request is accepted while busy;
- SOP and EOP never appear together, and every packet opens with SOP;
- the dword 0 length field is correct;
- rejects never overlap beats;
- the root bus number moves only at the end of a packet.

Only the directed scenarios can show the field-level results. These include the format/type and tag choice, the byte enables and lane shifts for each size and offset, the extra padding beat for aligned writes, and the two filter outcomes. They also include the snooped root bus update and its effect on the encoding and filtering of later requests.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HEAD = 2'd1,
        ST_PAD  = 2'd2,
        ST_TAIL = 2'd3
    } cfgb_state_e;

    localparam logic [7:0] FMT_RD_T0 = 8'h04;
    localparam logic [7:0] FMT_WR_T0 = 8'h44;
    localparam logic [7:0] FMT_RD_T1 = 8'h05;
    localparam logic [7:0] FMT_WR_T1 = 8'h45;
    localparam logic [7:0] TAG_RD    = 8'h1D;
    localparam logic [7:0] TAG_WR    = 8'h10;

    localparam int unsigned HIDDEN_BAR_OFF = 'h10;
    localparam int unsigned PRIBUS_OFF     = 'h18;

    localparam logic [1:0] REJ_NODEV  = 2'd1;
    localparam logic [1:0] REJ_BADREG = 2'd2;
endpackage

// File: rtl/cfgb_lanes.sv
module cfgb_lanes #(
    parameter int DW = 32
) (
    input  logic [1:0]      off_lo,
    input  logic [1:0]      size_code,
    input  logic [DW-1:0]   wdata,
    output logic [DW/8-1:0] byte_en,
    output logic [DW-1:0]   wdata_sh
);
    localparam int BE_W = DW / 8;

    always_comb begin
        unique case (size_code)
            2'd0:    byte_en = BE_W'(1) << off_lo;
            2'd1:    byte_en = BE_W'(3) << off_lo;
            default: byte_en = '1;
        endcase
        wdata_sh = wdata << {off_lo, 3'b000};
    end
endmodule

// File: rtl/cfgb_hdr.sv
module cfgb_hdr
    import cfgb_pkg::*;
#(
    parameter int BUS_W   = 8,
    parameter int DEVFN_W = 8,
    parameter int OFF_W   = 12
) (
    input  logic               is_write,
    input  logic               type1,
    input  logic [BUS_W-1:0]   root_bus,
    input  logic [3:0]         byte_en,
    input  logic [BUS_W-1:0]   bus,
    input  logic [DEVFN_W-1:0] devfn,
    input  logic [OFF_W-3:0]   off_dw,
    output logic [31:0]        dw0,
    output logic [31:0]        dw1,
    output logic [31:0]        dw2
);
    logic [7:0] fmt;
    logic [7:0] tag;

    always_comb begin
        unique case ({is_write, type1})
            2'b00:   fmt = FMT_RD_T0;
            2'b01:   fmt = FMT_RD_T1;
            2'b10:   fmt = FMT_WR_T0;
            default: fmt = FMT_WR_T1;
        endcase
        tag = is_write ? TAG_WR : TAG_RD;
        dw0 = {fmt, 24'h000001};
        dw1 = {8'(root_bus), 8'h00, tag, 4'h0, byte_en};
        dw2 = {8'(bus), 8'(devfn), 16'({off_dw, 2'b00})};
    end
endmodule

// File: rtl/cfg_req_builder.sv
module cfg_req_builder
    import cfgb_pkg::*;
#(
    parameter int              BUS_W     = 8,
    parameter int              DEVFN_W   = 8,
    parameter int              OFF_W     = 12,
    parameter logic [BUS_W-1:0] ROOT_INIT = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [BUS_W-1:0]   req_bus,
    input  logic [DEVFN_W-1:0] req_devfn,
    input  logic [OFF_W-1:0]   req_off,
    input  logic [1:0]         req_size,
    input  logic [31:0]        req_wdata,
    output logic               busy,
    output logic               reject_valid,
    output logic [1:0]         reject_code,
    output logic [BUS_W-1:0]   root_bus,
    output logic               beat_valid,
    input  logic               beat_ready,
    output logic [63:0]        beat_data,
    output logic               beat_sop,
    output logic               beat_eop
);
    localparam int DW     = 32;
    localparam int BE_W   = DW / 8;
    localparam int DEV_LO = 3;

    cfgb_state_e state, state_nx;

    logic               r_write, r_type1, r_aligned;
    logic [BUS_W-1:0]   r_bus;
    logic [DEVFN_W-1:0] r_devfn;
    logic [OFF_W-3:0]   r_off_dw;
    logic [BE_W-1:0]    r_be;
    logic [DW-1:0]      r_data;

    logic [BE_W-1:0]    be_c;
    logic [DW-1:0]      sh_c;
    logic [31:0]        dw0, dw1, dw2;

    logic accept, root_hit, hide_bar, no_dev, filtered, beat_take, snoop;

    cfgb_lanes #(.DW(DW)) u_lanes (
        .off_lo    (req_off[1:0]),
        .size_code (req_size),
        .wdata     (req_wdata),
        .byte_en   (be_c),
        .wdata_sh  (sh_c)
    );

    cfgb_hdr #(.BUS_W(BUS_W), .DEVFN_W(DEVFN_W), .OFF_W(OFF_W)) u_hdr (
        .is_write (r_write),
        .type1    (r_type1),
        .root_bus (root_bus),
        .byte_en  (r_be),
        .bus      (r_bus),
        .devfn    (r_devfn),
        .off_dw   (r_off_dw),
        .dw0      (dw0),
        .dw1      (dw1),
        .dw2      (dw2)
    );

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign root_hit  = (req_bus == root_bus);
    assign hide_bar  = root_hit && (req_devfn == '0) && (req_off == OFF_W'(HIDDEN_BAR_OFF));
    assign no_dev    = root_hit && (req_devfn[DEVFN_W-1:DEV_LO] != '0);
    assign filtered  = hide_bar || no_dev;
    assign beat_take = beat_valid && beat_ready;
    assign snoop     = r_write && (r_bus == root_bus) && (r_devfn == '0) &&
                       ({r_off_dw, 2'b00} == OFF_W'(PRIBUS_OFF)) && r_be[0];

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (accept && !filtered) state_nx = ST_HEAD;
            ST_HEAD: if (beat_take) state_nx = (r_write && r_aligned) ? ST_PAD : ST_TAIL;
            ST_PAD:  if (beat_take) state_nx = ST_TAIL;
            ST_TAIL: if (beat_take) state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // request capture, reject pulse, root bus tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_write      <= 1'b0;
            r_type1      <= 1'b0;
            r_aligned    <= 1'b0;
            r_bus        <= '0;
            r_devfn      <= '0;
            r_off_dw     <= '0;
            r_be         <= '0;
            r_data       <= '0;
            reject_valid <= 1'b0;
            reject_code  <= '0;
            root_bus     <= ROOT_INIT;
        end else begin
            reject_valid <= accept && filtered;
            if (accept) begin
                reject_code <= hide_bar ? REJ_BADREG : (no_dev ? REJ_NODEV : 2'd0);
                r_write     <= req_write;
                r_type1     <= !root_hit;
                r_aligned   <= !req_off[2];
                r_bus       <= req_bus;
                r_devfn     <= req_devfn;
                r_off_dw    <= req_off[OFF_W-1:2];
                r_be        <= be_c;
                r_data      <= sh_c;
            end
            if (state == ST_TAIL && beat_take && snoop)
                root_bus <= BUS_W'(r_data[7:0]);
        end
    end

    // outputs
    always_comb begin
        busy       = (state != ST_IDLE);
        beat_valid = 1'b0;
        beat_sop   = 1'b0;
        beat_eop   = 1'b0;
        beat_data  = '0;
        unique case (state)
            ST_IDLE: ;
            ST_HEAD: begin
                beat_valid = 1'b1;
                beat_sop   = 1'b1;
                beat_data  = {dw1, dw0};
            end
            ST_PAD: begin
                beat_valid = 1'b1;
                beat_data  = {32'h0, dw2};
            end
            ST_TAIL: begin
                beat_valid = 1'b1;
                beat_eop   = 1'b1;
                if (r_write && r_aligned) beat_data = {32'h0, r_data};
                else if (r_write)         beat_data = {r_data, dw2};
                else                      beat_data = {32'h0, dw2};
            end
        endcase
    end
endmodule

// File: rtl/cfg_req_builder_chk.sv
module cfg_req_builder_chk #(
    parameter int BUS_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             busy,
    input logic             reject_valid,
    input logic [BUS_W-1:0] root_bus,
    input logic             beat_valid,
    input logic             beat_ready,
    input logic [63:0]      beat_data,
    input logic             beat_sop,
    input logic             beat_eop
);
    p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && !beat_ready |=> beat_valid && $stable(beat_data) &&
                                      $stable(beat_sop) && $stable(beat_eop));

    p_no_accept_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !req_ready);

    p_flags_apart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> !(beat_sop && beat_eop));

    p_open_with_sop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(beat_valid) |-> beat_sop);

    p_len_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && beat_sop |-> beat_data[23:0] == 24'h000001);

    p_reject_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reject_valid |-> !beat_valid && !busy);

    p_root_moves_at_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(beat_valid && beat_ready && beat_eop) |=> $stable(root_bus));
endmodule

bind cfg_req_builder cfg_req_builder_chk #(.BUS_W(BUS_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_ready    (req_ready),
    .busy         (busy),
    .reject_valid (reject_valid),
    .root_bus     (root_bus),
    .beat_valid   (beat_valid),
    .beat_ready   (beat_ready),
    .beat_data    (beat_data),
    .beat_sop     (beat_sop),
    .beat_eop     (beat_eop)
);

// File: tb/cfg_req_builder_tb_top.sv
module cfg_req_builder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [7:0]  req_bus = '0;
    logic [7:0]  req_devfn = '0;
    logic [11:0] req_off = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        busy, reject_valid, beat_valid, beat_sop, beat_eop;
    logic [1:0]  reject_code;
    logic [7:0]  root_bus;
    logic        beat_ready = 1'b0;
    logic [63:0] beat_data;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] exp_root = 8'h00;
    bit done = 0;

    always #5 clk = ~clk;

    cfg_req_builder dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_bus(req_bus), .req_devfn(req_devfn),
        .req_off(req_off), .req_size(req_size), .req_wdata(req_wdata),
        .busy(busy), .reject_valid(reject_valid), .reject_code(reject_code),
        .root_bus(root_bus), .beat_valid(beat_valid), .beat_ready(beat_ready),
        .beat_data(beat_data), .beat_sop(beat_sop), .beat_eop(beat_eop)
    );

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic put_req(input bit w, input logic [7:0] bus, input logic [7:0] devfn,
                           input logic [11:0] off, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_bus = bus; req_devfn = devfn;
        req_off = off; req_size = sz; req_wdata = d;
        @(posedge clk);
    endtask

    // R1..R6, R9, R10: send one request and compare every beat
    task automatic run_pkt(input string tag, input bit w, input logic [7:0] bus,
                           input logic [7:0] devfn, input logic [11:0] off,
                           input logic [1:0] sz, input logic [31:0] d, input bit stall);
        logic [7:0]  fmt;
        logic [3:0]  be;
        logic [31:0] sh, dw0, dw1, dw2;
        logic [63:0] b [3];
        int n;
        bit t1;
        t1  = (bus != exp_root);
        fmt = w ? (t1 ? 8'h45 : 8'h44) : (t1 ? 8'h05 : 8'h04);
        be  = (sz == 2'd0) ? 4'(1 << off[1:0]) : (sz == 2'd1) ? 4'(3 << off[1:0]) : 4'hF;
        sh  = d << (8 * off[1:0]);
        dw0 = {fmt, 24'h000001};
        dw1 = {exp_root, 8'h00, (w ? 8'h10 : 8'h1D), 4'h0, be};
        dw2 = {bus, devfn, 4'h0, off[11:2], 2'b00};
        b[0] = {dw1, dw0};
        if (w && !off[2]) begin
            b[1] = {32'h0, dw2}; b[2] = {32'h0, sh}; n = 3;
        end else begin
            b[1] = {(w ? sh : 32'h0), dw2}; b[2] = '0; n = 2;
        end
        put_req(w, bus, devfn, off, sz, d);
        @(negedge clk);
        if (stall) begin
            req_bus = 8'hEE; req_off = 12'h3FC; // R10: ignored while busy
        end else req_valid = 1'b0;
        for (int k = 0; k < n; k++) begin
            chk({tag, " R10 busy"}, 64'(busy), 64'd1);
            chk({tag, " R6 valid"}, 64'(beat_valid), 64'd1);
            chk($sformatf("%s R1-fields beat%0d", tag, k), beat_data, b[k]);
            chk({tag, " R6 sop"}, 64'(beat_sop), 64'(k == 0));
            chk({tag, " R6 eop"}, 64'(beat_eop), 64'(k == n - 1));
            if (stall) begin
                beat_ready = 1'b0;
                @(negedge clk);
                chk({tag, " R10 held"}, beat_data, b[k]);
            end
            beat_ready = 1'b1;
            @(negedge clk);
            beat_ready = 1'b0;
        end
        req_valid = 1'b0;
        if (w && bus == exp_root && devfn == 8'h00 && {off[11:2], 2'b00} == 12'h018 && be[0])
            exp_root = sh[7:0];
        chk({tag, " R10 idle"}, 64'(busy), 64'd0);
        chk({tag, " R6 no extra beat"}, 64'(beat_valid), 64'd0);
        chk({tag, " R9 root"}, 64'(root_bus), 64'(exp_root));
    endtask

    // R7, R8: filtered request
    task automatic run_rej(input string tag, input logic [7:0] bus, input logic [7:0] devfn,
                           input logic [11:0] off, input logic [1:0] code);
        put_req(1'b0, bus, devfn, off, 2'd2, 32'h0);
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " reject pulse"}, 64'(reject_valid), 64'd1);
        chk({tag, " reject code"}, 64'(reject_code), 64'(code));
        chk({tag, " no beat"}, 64'(beat_valid), 64'd0);
        chk({tag, " not busy"}, 64'(busy), 64'd0);
        @(negedge clk);
        chk({tag, " pulse ends"}, 64'(reject_valid), 64'd0);
        chk({tag, " still no beat"}, 64'(beat_valid), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 busy", 64'(busy), 64'd0);
        chk("R11 beat_valid", 64'(beat_valid), 64'd0);
        chk("R11 reject_valid", 64'(reject_valid), 64'd0);
        chk("R11 req_ready", 64'(req_ready), 64'd1);
        chk("R9 root reset", 64'(root_bus), 64'd0);

        run_pkt("R1 rd t0",        1'b0, 8'h00, 8'h00, 12'h000, 2'd2, 32'h0, 1'b0);
        run_pkt("R5 rd t1 2B",     1'b0, 8'h01, 8'h08, 12'h006, 2'd1, 32'h0, 1'b0);
        run_pkt("R5 wr 1B",        1'b1, 8'h02, 8'h11, 12'h00D, 2'd0, 32'h000000AB, 1'b0);
        run_pkt("R6 wr aligned",   1'b1, 8'h03, 8'h20, 12'h108, 2'd2, 32'hCAFEF00D, 1'b1);
        run_pkt("R5 wr 2B off3",   1'b1, 8'h04, 8'h00, 12'h003, 2'd1, 32'h00001234, 1'b1);
        run_pkt("R4 rd ext",       1'b0, 8'h09, 8'h07, 12'hFFE, 2'd0, 32'h0, 1'b0);
        run_rej("R7 nodev",        8'h00, 8'h08, 12'h000, 2'd1);
        run_rej("R8 hidden bar",   8'h00, 8'h00, 12'h010, 2'd2);
        run_pkt("R8 bar other bus",1'b0, 8'h05, 8'h00, 12'h010, 2'd2, 32'h0, 1'b0);
        run_pkt("R3 fn on dev0",   1'b0, 8'h00, 8'h03, 12'h004, 2'd2, 32'h0, 1'b0);
        // R9: write to another bus at 0x18 must not move root
        run_pkt("R9 no snoop",     1'b1, 8'h06, 8'h00, 12'h018, 2'd2, 32'h00000055, 1'b0);
        run_pkt("R9 snoop",        1'b1, 8'h00, 8'h00, 12'h018, 2'd2, 32'h00000207, 1'b0);
        chk("R9 root now 7", 64'(root_bus), 64'h07);
        run_pkt("R1 new root t0",  1'b0, 8'h07, 8'h00, 12'h000, 2'd2, 32'h0, 1'b0);
        run_pkt("R1 old root t1",  1'b1, 8'h00, 8'h08, 12'h00C, 2'd2, 32'h11223344, 1'b0);
        run_rej("R7 nodev newroot",8'h07, 8'h10, 12'h000, 2'd1);
        run_pkt("R9 byte snoop",   1'b1, 8'h07, 8'h00, 12'h018, 2'd0, 32'h0000003C, 1'b1);
        chk("R9 root now 3C", 64'(root_bus), 64'h3C);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog R10 actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule